// File: doc/BRIEF.md
# Framed Register Command Engine

The engine sits behind a byte-stream decoder and turns framed request traffic into register bus cycles. A frame opens with a start marker and closes with an end marker. Between them any number of requests follow one another. Each request begins with a command byte, then carries its operands and a check byte. The engine runs each request on a simple register bus as it arrives. It then writes a matching reply into an outgoing stream that carries its own start and end markers, so replies leave in the order the requests came in.

Each command byte holds a 5-bit tag in bits 7:3 and an operation code in bits 2:0. The whole byte is echoed at the head of its reply, so the host can pair replies with requests. Requests and replies are each protected by a CRC-8 byte. A request that fails the check is answered but never executed. The input side stalls through `in_ready` while a request executes and its reply is sent out. The output side has no backpressure.

Top module: `fcmd_engine`

## Requirements
- R1: A command byte is split as tag = bits 7:3 and op = bits 2:0. Op 3'b000 is read, 3'b010 is write and 3'b110 is init. The first byte of every reply is the command byte, unchanged.
- R2: A write request is cmd, address, data low, data high, check. It gives exactly one `bus_wr` pulse with `bus_addr` = address and `bus_wdata` = {high, low}. Its reply is cmd, status 8'h00, check.
- R3: A read request is cmd, address, check. It gives one `bus_rd` pulse. `bus_rdata` is taken in the cycle after the pulse. The reply is cmd, data low, data high, status 8'h00, check.
- R4: An init request has the write layout. It gives one `bus_init` pulse with `bus_addr` and `bus_wdata` set from its operands, and no `bus_wr`. Its reply is cmd, status, check.
- R5: The check byte is CRC-8 with polynomial 0x07, MSB first, start value 0. A request's check covers that request's bytes before the check. A reply's check covers that reply's bytes before the check.
- R6: When a request's check byte does not match, no strobe is issued and status bit 0 is set (8'h01). A read reply then carries 8'h00 in both data bytes.
- R7: Any other op expects cmd followed by a check byte. It issues no strobe and is answered with cmd, status 8'h02, check.
- R8: An accepted start marker produces an output start marker, and an accepted end marker produces an output end marker. Between them comes one reply per request, in request order, with many requests in one frame.
- R9: Bytes and end markers received outside a frame produce no output and no strobe.
- R10: An end marker before a request is complete drops that request. There is no strobe and no reply, and the end marker is still passed on.
- R11: At most one of `bus_wr`, `bus_rd`, `bus_init` is high in any cycle. Each is high for one cycle only, and `in_ready` is low while any is high.
- R12: During and right after reset, `in_ready` is high and `out_valid` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Engine accepts an input item this cycle |
| in_sop | input | 1 | Item is a frame start marker |
| in_eop | input | 1 | Item is a frame end marker |
| in_byte | input | 8 | Request byte (ignored for markers) |
| out_valid | output | 1 | Output item present |
| out_sop | output | 1 | Output item is a start marker |
| out_eop | output | 1 | Output item is an end marker |
| out_byte | output | 8 | Reply byte (zero for markers) |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 16 | Register write word |
| bus_rdata | input | 16 | Register read word, valid the cycle after `bus_rd` |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_init | output | 1 | Init strobe |

## Verification
On every cycle, the assertions enforce the strobe rules: one strobe at a time, one cycle wide, with input stalled while a strobe is high. They also check that the serializer is never loaded while it is still sending, and that the outputs are quiet after reset. The properties cannot show the content of replies, the CRC values, execution being suppressed on a bad check, unknown ops, traffic outside a frame, or frames cut short. Only the bench scenarios show these, by comparing the complete output stream and a register model against values computed independently.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned REPLY_N = 4;

  localparam logic [2:0] OP_READ  = 3'b000;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_INIT  = 3'b110;

  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_DLO, S_DHI, S_CHK, S_STRB, S_CAP, S_SEND
  } eng_state_t;

  function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
    logic [7:0] x;
    x = acc ^ din;
    for (int b = 0; b < 8; b++) begin
      x = x[7] ? ((x << 1) ^ CRC_POLY) : (x << 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/fcmd_crc_acc.sv
module fcmd_crc_acc (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  import fcmd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= 8'h00;
    else if (upd)   crc <= crc8_step(crc, din);
  end
endmodule

// File: rtl/fcmd_tx.sv
module fcmd_tx #(
  parameter  int unsigned NBYTES = 4,
  localparam int unsigned LW     = $clog2(NBYTES + 1),
  localparam int unsigned IW     = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LW-1:0]     load_len,
  input  logic [NBYTES*8-1:0] load_bytes,
  input  logic              mark_sop,
  input  logic              mark_eop,
  output logic              busy,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [7:0]        out_byte
);
  logic [7:0]    hold_q [NBYTES];
  logic [LW-1:0] len_q, idx_q;
  logic [7:0]    crc_now, cur;
  logic          last;

  assign last = (idx_q == len_q);
  assign cur  = last ? crc_now : hold_q[idx_q[IW-1:0]];

  fcmd_crc_acc u_crc (
    .clk (clk),
    .rst (rst),
    .clr (load),
    .upd (busy && !last),
    .din (cur),
    .crc (crc_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      len_q     <= '0;
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_byte  <= 8'h00;
      for (int k = 0; k < NBYTES; k++) hold_q[k] <= 8'h00;
    end else begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      if (load) begin
        for (int k = 0; k < NBYTES; k++) hold_q[k] <= load_bytes[k*8 +: 8];
        len_q <= load_len;
        idx_q <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        out_valid <= 1'b1;
        out_byte  <= cur;
        idx_q     <= idx_q + LW'(1);
        if (last) busy <= 1'b0;
      end else if (mark_sop) begin
        out_valid <= 1'b1;
        out_sop   <= 1'b1;
        out_byte  <= 8'h00;
      end else if (mark_eop) begin
        out_valid <= 1'b1;
        out_eop   <= 1'b1;
        out_byte  <= 8'h00;
      end
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy); // R8

  AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R12
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  output logic        out_sop,
  output logic        out_eop,
  output logic [7:0]  out_byte,
  output logic [7:0]  bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic        bus_init
);
  import fcmd_pkg::*;

  localparam int unsigned LW = $clog2(REPLY_N + 1);

  eng_state_t st;
  logic [7:0] cmd_q;
  logic       bad_q;
  logic [7:0] rx_crc;
  logic       fire, is_data, parsing, tx_busy;
  logic [2:0] op_q, op_in;
  logic       known_q, op_in_known;
  logic [7:0] status;
  logic [REPLY_N*8-1:0] reply;
  logic [LW-1:0]        reply_len;

  assign parsing  = (st == S_IDLE) || (st == S_CMD) || (st == S_ADDR) ||
                    (st == S_DLO)  || (st == S_DHI) || (st == S_CHK);
  assign in_ready = parsing;
  assign fire     = in_valid && in_ready;
  assign is_data  = fire && !in_sop && !in_eop && (st != S_IDLE);

  assign op_q        = cmd_q[2:0];
  assign op_in       = in_byte[2:0];
  assign known_q     = (op_q == OP_READ) || (op_q == OP_WRITE) || (op_q == OP_INIT);
  assign op_in_known = (op_in == OP_READ) || (op_in == OP_WRITE) || (op_in == OP_INIT);

  fcmd_crc_acc u_rx_crc (
    .clk (clk),
    .rst (rst),
    .clr ((fire && in_sop) || (is_data && st == S_CHK)),
    .upd (is_data && st != S_CHK),
    .din (in_byte),
    .crc (rx_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cmd_q     <= 8'h00;
      bad_q     <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_init  <= 1'b0;
    end else begin
      bus_wr   <= 1'b0;
      bus_rd   <= 1'b0;
      bus_init <= 1'b0;
      case (st)
        S_IDLE: if (fire && in_sop) st <= S_CMD;
        S_STRB: st <= S_CAP;
        S_CAP:  st <= S_SEND;
        S_SEND: if (!tx_busy) st <= S_CMD;
        default: begin
          if (fire && in_sop)      st <= S_CMD;
          else if (fire && in_eop) st <= S_IDLE;
          else if (is_data) begin
            case (st)
              S_CMD: begin
                cmd_q <= in_byte;
                st    <= op_in_known ? S_ADDR : S_CHK;
              end
              S_ADDR: begin
                bus_addr <= in_byte;
                st       <= (op_q == OP_READ) ? S_CHK : S_DLO;
              end
              S_DLO: begin
                bus_wdata[7:0] <= in_byte;
                st             <= S_DHI;
              end
              S_DHI: begin
                bus_wdata[15:8] <= in_byte;
                st              <= S_CHK;
              end
              default: begin
                bad_q <= (in_byte != rx_crc);
                if (in_byte == rx_crc) begin
                  bus_wr   <= (op_q == OP_WRITE);
                  bus_rd   <= (op_q == OP_READ);
                  bus_init <= (op_q == OP_INIT);
                end
                st <= S_STRB;
              end
            endcase
          end
        end
      endcase
    end
  end

  assign status = {6'b000000, !known_q, bad_q};

  always_comb begin
    reply        = '0;
    reply[7:0]   = cmd_q;
    if (op_q == OP_READ) begin
      reply[15:8]  = bad_q ? 8'h00 : bus_rdata[7:0];
      reply[23:16] = bad_q ? 8'h00 : bus_rdata[15:8];
      reply[31:24] = status;
      reply_len    = LW'(4);
    end else begin
      reply[15:8]  = status;
      reply_len    = LW'(2);
    end
  end

  fcmd_tx #(.NBYTES(REPLY_N)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .load       (st == S_CAP),
    .load_len   (reply_len),
    .load_bytes (reply),
    .mark_sop   (fire && in_sop),
    .mark_eop   (fire && in_eop && st != S_IDLE),
    .busy       (tx_busy),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_byte   (out_byte)
  );

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_wr, bus_rd, bus_init})); // R11

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd || bus_init) |=> !(bus_wr || bus_rd || bus_init)); // R11

  AST_STROBE_STALL: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd || bus_init) |-> !in_ready); // R11

  AST_STROBE_QUIET_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(bus_wr || bus_rd || bus_init)); // R12
endmodule

// File: tb/fcmd_engine_tb.sv
module fcmd_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, out_valid, out_sop, out_eop;
  logic [7:0]  out_byte, bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd, bus_init;

  int checks = 0, errors = 0;
  int wr_cnt, rd_cnt, init_cnt;
  logic [7:0]  init_addr;
  logic [15:0] init_data;
  logic [15:0] mem [256];
  logic [9:0]  got_q [$];
  logic [9:0]  exp_q [$];

  always #10 clk = ~clk;

  fcmd_engine u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_byte(out_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_init(bus_init)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
      bus_rdata <= 16'h0000;
      wr_cnt <= 0; rd_cnt <= 0; init_cnt <= 0;
      init_addr <= 8'h00; init_data <= 16'h0000;
    end else begin
      if (bus_wr) begin mem[bus_addr] <= bus_wdata; wr_cnt <= wr_cnt + 1; end
      if (bus_rd) begin bus_rdata <= mem[bus_addr]; rd_cnt <= rd_cnt + 1; end
      if (bus_init) begin
        init_cnt <= init_cnt + 1; init_addr <= bus_addr; init_data <= bus_wdata;
      end
    end
  end

  always @(negedge clk) if (out_valid) got_q.push_back({out_sop, out_eop, out_byte});

  function automatic logic [7:0] tb_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit s, input bit e, input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sop = s; in_eop = e; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = 8'h00;
  endtask

  task automatic open_frame();  put(1'b1, 1'b0, 8'h00); exp_q.push_back(10'h200); endtask
  task automatic close_frame(); put(1'b0, 1'b1, 8'h00); exp_q.push_back(10'h100); endtask

  task automatic send_req(input logic [7:0] b [5], input int n, input bit corrupt);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      put(1'b0, 1'b0, b[i]);
      c = tb_crc(c, b[i]);
    end
    put(1'b0, 1'b0, corrupt ? (c ^ 8'h5A) : c);
  endtask

  task automatic exp_reply(input logic [7:0] r [4], input int n);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({2'b00, r[i]});
      c = tb_crc(c, r[i]);
    end
    exp_q.push_back({2'b00, c});
  endtask

  // write (op 3'b010) or init (op 3'b110): cmd, addr, lo, hi, check
  task automatic req_wr(input logic [4:0] seq, input logic [2:0] op, input logic [7:0] a,
                        input logic [15:0] d, input bit corrupt);
    logic [7:0] cmd;
    cmd = {seq, op};
    send_req('{cmd, a, d[7:0], d[15:8], 8'h00}, 4, corrupt);
    exp_reply('{cmd, corrupt ? 8'h01 : 8'h00, 8'h00, 8'h00}, 2);
  endtask

  task automatic req_rd(input logic [4:0] seq, input logic [7:0] a, input logic [15:0] d,
                        input bit corrupt);
    logic [7:0] cmd;
    cmd = {seq, 3'b000};
    send_req('{cmd, a, 8'h00, 8'h00, 8'h00}, 2, corrupt);
    exp_reply('{cmd, corrupt ? 8'h00 : d[7:0], corrupt ? 8'h00 : d[15:8],
                corrupt ? 8'h01 : 8'h00}, 4);
  endtask

  task automatic begin_case();
    repeat (2) @(negedge clk);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic compare_stream(input string req);
    int n;
    repeat (30) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      if (got_q[i] != exp_q[i]) begin
        chk(1'b0, req, {22'd0, got_q[i]}, {22'd0, exp_q[i]});
        return;
      end
    end
    chk(1'b1, req, 0, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R12 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
    chk({bus_wr, bus_rd, bus_init} == 3'b000, "R12 strobes", {bus_wr, bus_rd, bus_init}, 0);
  endtask

  task automatic t_write_read();
    int w0, r0;
    begin_case();
    w0 = wr_cnt; r0 = rd_cnt;
    open_frame();
    req_wr(5'd1, 3'b010, 8'h11, 16'h33CC, 1'b0);
    req_rd(5'd2, 8'h11, 16'h33CC, 1'b0);
    close_frame();
    compare_stream("R1 R3 R5 R8 write then read stream");
    chk(mem[8'h11] == 16'h33CC, "R2 register written", mem[8'h11], 16'h33CC);
    chk(wr_cnt - w0 == 1, "R11 one write strobe", wr_cnt - w0, 1);
    chk(rd_cnt - r0 == 1, "R11 one read strobe", rd_cnt - r0, 1);
  endtask

  task automatic t_batch();
    begin_case();
    open_frame();
    req_wr(5'd3, 3'b010, 8'h22, 16'h80FF, 1'b0);
    req_rd(5'd4, 8'h22, 16'h80FF, 1'b0);
    req_wr(5'd5, 3'b010, 8'h23, 16'h8281, 1'b0);
    req_rd(5'd6, 8'h23, 16'h8281, 1'b0);
    req_rd(5'd7, 8'h11, 16'h33CC, 1'b0);
    req_wr(5'd31, 3'b010, 8'h11, 16'h0000, 1'b0);
    req_rd(5'd0, 8'h11, 16'h0000, 1'b0);
    close_frame();
    compare_stream("R8 R5 R1 batched frame");
    chk(mem[8'h23] == 16'h8281, "R2 batched write", mem[8'h23], 16'h8281);
  endtask

  task automatic t_init();
    int i0, w0;
    begin_case();
    i0 = init_cnt; w0 = wr_cnt;
    open_frame();
    req_wr(5'd30, 3'b110, 8'hFE, 16'h1008, 1'b0);
    close_frame();
    compare_stream("R4 init reply");
    chk(init_cnt - i0 == 1, "R4 init strobe count", init_cnt - i0, 1);
    chk(init_addr == 8'hFE && init_data == 16'h1008, "R4 init operands",
        {init_addr, init_data}, {8'hFE, 16'h1008});
    chk(wr_cnt == w0 && mem[8'hFE] == 16'h0000, "R4 no write from init", wr_cnt - w0, 0);
  endtask

  task automatic t_crc_bad();
    int w0, r0;
    begin_case();
    w0 = wr_cnt; r0 = rd_cnt;
    open_frame();
    req_wr(5'd8, 3'b010, 8'h23, 16'hBEEF, 1'b1);
    req_rd(5'd9, 8'h23, 16'h8281, 1'b1);
    req_rd(5'd10, 8'h23, 16'h8281, 1'b0);
    close_frame();
    compare_stream("R6 bad check replies");
    chk(mem[8'h23] == 16'h8281, "R6 write suppressed", mem[8'h23], 16'h8281);
    chk(wr_cnt == w0 && rd_cnt - r0 == 1, "R6 strobes suppressed", rd_cnt - r0, 1);
  endtask

  task automatic t_unknown();
    int s0;
    begin_case();
    s0 = wr_cnt + rd_cnt + init_cnt;
    open_frame();
    send_req('{8'h29, 8'h00, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
    exp_reply('{8'h29, 8'h02, 8'h00, 8'h00}, 2);
    send_req('{8'h5F, 8'h00, 8'h00, 8'h00, 8'h00}, 1, 1'b0);
    exp_reply('{8'h5F, 8'h02, 8'h00, 8'h00}, 2);
    req_rd(5'd11, 8'h22, 16'h80FF, 1'b0);
    close_frame();
    compare_stream("R7 unsupported op replies");
    chk(wr_cnt + rd_cnt + init_cnt - s0 == 1, "R7 no strobe for unknown op",
        wr_cnt + rd_cnt + init_cnt - s0, 1);
  endtask

  task automatic t_outside();
    int s0;
    begin_case();
    s0 = wr_cnt + rd_cnt + init_cnt;
    put(1'b0, 1'b0, 8'h0A); put(1'b0, 1'b0, 8'h40);
    put(1'b0, 1'b0, 8'h34); put(1'b0, 1'b0, 8'h12);
    put(1'b0, 1'b0, 8'h00); put(1'b0, 1'b1, 8'h00);
    compare_stream("R9 no output outside frame");
    chk(mem[8'h40] == 16'h0000 && wr_cnt + rd_cnt + init_cnt == s0,
        "R9 no strobe outside frame", mem[8'h40], 0);
  endtask

  task automatic t_abort();
    int s0;
    begin_case();
    s0 = wr_cnt + rd_cnt + init_cnt;
    open_frame();
    put(1'b0, 1'b0, 8'h62); put(1'b0, 1'b0, 8'h41); put(1'b0, 1'b0, 8'h55);
    close_frame();
    compare_stream("R10 cut request has no reply");
    chk(mem[8'h41] == 16'h0000 && wr_cnt + rd_cnt + init_cnt == s0,
        "R10 cut request not executed", mem[8'h41], 0);
    begin_case();
    open_frame();
    req_rd(5'd12, 8'h22, 16'h80FF, 1'b0);
    close_frame();
    compare_stream("R10 next frame after cut request");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_batch();
    t_init();
    t_crc_bad();
    t_unknown();
    t_outside();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule